// File: doc/BRIEF.md
# Multiplexed Bus Machine Cycle Sequencer

This block runs the external bus of a small processor core whose low address byte and data byte share one set of lines. The core asks for one bus cycle at a time by giving a cycle kind (opcode fetch, memory read, I/O read or memory write), an address, the program counter value and the byte to write. The sequencer then steps through the bus states, one clock per state. It drives the upper address byte, the shared address/data byte with its output enable, the address latch strobe, the read and write strobes, the memory/I/O select and a two-bit status code.

A slow target stretches a cycle by holding `ready` low. Each low sample taken in the second state, or in a wait state, adds one more wait state. When a read ends, the byte on the shared lines is captured and returned with a one-clock `done` pulse. Writes also produce `done`. The tri-state pad that merges `ad_out`, `ad_oe` and `ad_in` sits outside this block.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset, `ale` is 0, `rd_n` and `wr_n` are 1, `ad_oe` is 0, `io_m` is 0, {`s1`,`s0`} is 00, `done` is 0 and `req_ready` is 1.
- R2: `ale` is 1 only in the first state (T1) of a cycle. In T1, `ad_oe` is 1, `ad_out` carries the low byte of the cycle address and `a_hi` carries the high byte.
- R3: An I/O read (`req_kind`=2) drives `req_addr[7:0]` onto both `a_hi` and `ad_out` in T1 and holds `io_m` at 1 for the whole cycle. Memory cycles and fetches hold `io_m` at 0.
- R4: While a cycle runs, {`s1`,`s0`} is 11 for an opcode fetch (`req_kind`=0), 10 for a memory read (`req_kind`=1) or I/O read, and 01 for a memory write (`req_kind`=3). Between cycles it is 00.
- R5: In a read or fetch, `ad_oe` is 0 from T2 until the next T1, and `rd_n` is 0 from T2 through T3 including any wait states. `rd_n` and `wr_n` are never both 0.
- R6: In a write, `ad_out` carries the write byte and `ad_oe` stays 1 from T2 until the next T1. `wr_n` is 0 in T2 and in the wait states and 1 in T3. `a_hi` and `ad_out` do not change while the bus is idle.
- R7: `ready` is sampled at the end of T2 and at the end of each wait state. Each low sample adds exactly one wait state, and the first high sample moves the cycle to T3.
- R8: Memory read, I/O read and write cycles last 3 states plus the wait states. An opcode fetch lasts 4 states (`req_long`=0) or 6 states (`req_long`=1) plus the wait states, and its address is taken from `pc`, not from `req_addr`. `req_long` has no effect on other kinds.
- R9: `rd_data` takes the value `ad_in` had at the end of T3. `done` is 1 for exactly the one clock after T3.
- R10: A request is taken only while `req_ready` is 1. That is while idle or in the final state of a cycle, and in the final state the next T1 follows at once. A request shown at any other time has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request |
| req_kind | input | 2 | 0 fetch, 1 memory read, 2 I/O read, 3 memory write |
| req_long | input | 1 | Fetch uses 6 states instead of 4 |
| req_addr | input | 16 | Memory address; low byte is the port number for I/O |
| pc | input | 16 | Program counter, used as the fetch address |
| req_wdata | input | 8 | Byte to write |
| req_ready | output | 1 | Request is taken this clock if valid |
| ready | input | 1 | Target ready; low inserts wait states |
| a_hi | output | 8 | Upper address byte |
| ad_out | output | 8 | Shared address/data byte, outbound |
| ad_in | input | 8 | Shared address/data byte, inbound |
| ad_oe | output | 1 | Output enable for the shared byte |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 for I/O cycles, 0 for memory cycles |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-clock cycle-complete pulse |

## Verification
The bench sweeps every cycle kind, with both fetch lengths, against zero to three wait states, and computes the expected output of every state from the state index. A design that samples `ready` one state late would add an extra wait state or drop one, and so stretch or shorten the `rd_n` and `wr_n` windows. A design that captures `ad_in` one clock early or late would return the inverted filler byte that the bench drives outside T3. Further runs check that I/O cycles duplicate the port byte, that a fetch ignores `req_addr` and `req_long` matters only for fetches, that a write leaves `wr_n` high in T3, and that a request raised in T2 is ignored and not taken in the middle of a cycle.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        CYC_FETCH = 2'd0,
        CYC_MRD   = 2'd1,
        CYC_IORD  = 2'd2,
        CYC_MWR   = 2'd3
    } cyc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4,
        ST_T4   = 3'd5,
        ST_T5   = 3'd6,
        ST_T6   = 3'd7
    } bus_state_e;

endpackage

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_long,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] req_wdata,
    input  logic          ready,
    output bus_state_e    state_q,
    output cyc_kind_e     kind_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic          req_ready
);

    localparam int PW = AW - DW;

    typedef struct packed {
        bus_state_e    st;
        cyc_kind_e     kind;
        logic          lng;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } fsm_t;

    fsm_t r_d, r_q;
    logic last_st;
    logic take;
    cyc_kind_e kind_in;

    always_comb begin
        r_d     = r_q;
        kind_in = cyc_kind_e'(req_kind);
        last_st = ((r_q.st == ST_T3) && (r_q.kind != CYC_FETCH)) ||
                  ((r_q.st == ST_T4) && !r_q.lng) ||
                  (r_q.st == ST_T6);
        take    = req_valid && ((r_q.st == ST_IDLE) || last_st);

        unique case (r_q.st)
            ST_T1:   r_d.st = ST_T2;
            ST_T2,
            ST_TW:   r_d.st = ready ? ST_T3 : ST_TW;
            ST_T3:   r_d.st = (r_q.kind == CYC_FETCH) ? ST_T4 : ST_IDLE;
            ST_T4:   r_d.st = r_q.lng ? ST_T5 : ST_IDLE;
            ST_T5:   r_d.st = ST_T6;
            ST_T6:   r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase

        if (take) begin
            r_d.st    = ST_T1;
            r_d.kind  = kind_in;
            r_d.lng   = req_long && (kind_in == CYC_FETCH);
            r_d.wdata = req_wdata;
            unique case (kind_in)
                CYC_FETCH: r_d.addr = pc;
                CYC_IORD:  r_d.addr = {req_addr[PW-1:0], req_addr[DW-1:0]};
                default:   r_d.addr = req_addr;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.kind  <= CYC_MRD;
            r_q.lng   <= 1'b0;
            r_q.addr  <= '0;
            r_q.wdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_q   = r_q.st;
    assign kind_q    = r_q.kind;
    assign addr_q    = r_q.addr;
    assign wdata_q   = r_q.wdata;
    assign req_ready = (r_q.st == ST_IDLE) || last_st;

    AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_T1) |=> (r_q.st == ST_T2)); // R8
    AST_WAIT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_T2 || r_q.st == ST_TW) && !ready) |=> (r_q.st == ST_TW)); // R7
    AST_T3_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_T2 || r_q.st == ST_TW) && ready) |=> (r_q.st == ST_T3)); // R7
    AST_NO_MIDCYCLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && r_q.st != ST_T2 && r_q.st != ST_TW) |=> $stable(r_q.addr)); // R10

endmodule

// File: rtl/bcs_drive.sv
module bcs_drive
    import bcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_state_e    state_q,
    input  cyc_kind_e     kind_q,
    input  logic [AW-1:0] addr_q,
    input  logic [DW-1:0] wdata_q,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m,
    output logic          s1,
    output logic          s0
);

    logic active, is_rd, strobe_win, first;

    always_comb begin
        active     = (state_q != ST_IDLE);
        first      = (state_q == ST_T1);
        is_rd      = (kind_q != CYC_MWR);
        strobe_win = (state_q == ST_T2) || (state_q == ST_TW);

        ale    = first;
        rd_n   = !(is_rd && (strobe_win || state_q == ST_T3));
        wr_n   = !(!is_rd && strobe_win);
        io_m   = active && (kind_q == CYC_IORD);
        a_hi   = addr_q[AW-1:DW];
        ad_oe  = first || !is_rd;
        ad_out = (first || is_rd) ? addr_q[DW-1:0] : wdata_q;

        unique case (kind_q)
            CYC_FETCH: {s1, s0} = 2'b11;
            CYC_MWR:   {s1, s0} = 2'b01;
            default:   {s1, s0} = 2'b10;
        endcase
        if (!active) {s1, s0} = 2'b00;
    end

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R5
    AST_IO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && io_m) |-> (a_hi == ad_out)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ((state_q == ST_T1) || ($stable(a_hi) && $stable(ad_out)))); // R6

endmodule

// File: rtl/bcs_capture.sv
module bcs_capture
    import bcs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_state_e    state_q,
    input  cyc_kind_e     kind_q,
    input  logic [DW-1:0] ad_in,
    output logic [DW-1:0] rd_data,
    output logic          done
);

    typedef struct packed {
        logic [DW-1:0] data;
        logic          done;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = (state_q == ST_T3);
        if ((state_q == ST_T3) && (kind_q != CYC_MWR))
            c_d.data = ad_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.data <= '0;
            c_q.done <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_data = c_q.data;
    assign done    = c_q.done;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |=> !c_q.done); // R9
    AST_DONE_AFTER_T3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T3) |=> c_q.done); // R9

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_kind,
    input  logic          req_long,
    input  logic [AW-1:0] req_addr,
    input  logic [AW-1:0] pc,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    input  logic          ready,
    output logic [AW-DW-1:0] a_hi,
    output logic [DW-1:0] ad_out,
    input  logic [DW-1:0] ad_in,
    output logic          ad_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          io_m,
    output logic          s1,
    output logic          s0,
    output logic [DW-1:0] rd_data,
    output logic          done
);

    bus_state_e    state_q;
    cyc_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;

    bcs_fsm #(.AW(AW), .DW(DW)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_long  (req_long),
        .req_addr  (req_addr),
        .pc        (pc),
        .req_wdata (req_wdata),
        .ready     (ready),
        .state_q   (state_q),
        .kind_q    (kind_q),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .req_ready (req_ready)
    );

    bcs_drive #(.AW(AW), .DW(DW)) drive_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .kind_q  (kind_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q),
        .a_hi    (a_hi),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .ale     (ale),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .io_m    (io_m),
        .s1      (s1),
        .s0      (s0)
    );

    bcs_capture #(.DW(DW)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .kind_q  (kind_q),
        .ad_in   (ad_in),
        .rd_data (rd_data),
        .done    (done)
    );

endmodule

// File: tb/bus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module bus_cycle_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd0;
    logic        req_long = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] pc = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        ready = 1'b1;
    logic [7:0]  a_hi, ad_out, rd_data;
    logic [7:0]  ad_in = '0;
    logic        ad_oe, ale, rd_n, wr_n, io_m, s1, s0, done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bus_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_long(req_long), .req_addr(req_addr), .pc(pc), .req_wdata(req_wdata),
        .req_ready(req_ready), .ready(ready), .a_hi(a_hi), .ad_out(ad_out),
        .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .io_m(io_m), .s1(s1), .s0(s0), .rd_data(rd_data), .done(done)
    );

    task automatic chk(input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s @%0t: actual %h expected %h", rq, what, $time, act, exp);
        end
    endtask

    // One full bus cycle followed by one idle state; expectations come from state index k.
    task automatic run_cycle(input int kind, input bit lng, input logic [15:0] addr,
                             input logic [15:0] pcv, input logic [7:0] wd,
                             input int w, input logic [7:0] rdv, input bit noise);
        bit isrd;
        int base, last, t3k;
        logic [15:0] ea;
        logic [1:0] code;
        isrd = (kind != 3);
        base = (kind == 0) ? (lng ? 6 : 4) : 3;
        last = base - 1 + w;
        t3k  = 2 + w;
        ea   = (kind == 0) ? pcv : (kind == 2) ? {addr[7:0], addr[7:0]} : addr;
        code = (kind == 0) ? 2'b11 : (kind == 3) ? 2'b01 : 2'b10;

        req_valid = 1'b1; req_kind = kind[1:0]; req_long = lng;
        req_addr = addr; pc = pcv; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k <= last + 1; k++) begin
            bit act;
            act = (k <= last);
            chk("R2", "ale", {15'd0, ale}, {15'd0, (k == 0)});
            chk("R2", "a_hi", {8'd0, a_hi}, {8'd0, ea[15:8]});
            chk("R5", "rd_n", {15'd0, rd_n}, {15'd0, !(isrd && k >= 1 && k <= t3k)});
            chk("R6", "wr_n", {15'd0, wr_n}, {15'd0, !(!isrd && k >= 1 && k < t3k)});
            chk("R5", "ad_oe", {15'd0, ad_oe}, {15'd0, (k == 0) || !isrd});
            if (k == 0) chk("R3", "ad_out T1", {8'd0, ad_out}, {8'd0, ea[7:0]});
            else if (!isrd) chk("R6", "ad_out data", {8'd0, ad_out}, {8'd0, wd});
            chk("R3", "io_m", {15'd0, io_m}, {15'd0, act && kind == 2});
            chk("R4", "status", {14'd0, s1, s0}, {14'd0, act ? code : 2'b00});
            chk("R9", "done", {15'd0, done}, {15'd0, (k == t3k + 1)});
            chk("R8", "req_ready", {15'd0, req_ready}, {15'd0, (k >= last)});
            if (k == t3k + 1 && isrd)
                chk("R9", "rd_data", {8'd0, rd_data}, {8'd0, rdv});
            // drive for the coming edge
            ready = !(k >= 1 && k <= w);   // R7: w low samples give w wait states
            ad_in = (k == t3k) ? rdv : ~rdv;
            if (noise && k == 1) begin     // R10: request while busy
                req_valid = 1'b1; req_kind = 2'd3; req_addr = 16'hFFFF;
                pc = 16'hEEEE; req_wdata = 8'hDD;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        ready = 1'b1;
        // R6: idle keeps the address lines still
        chk("R6", "idle a_hi hold", {8'd0, a_hi}, {8'd0, ea[15:8]});
        if (!isrd) chk("R6", "idle data hold", {8'd0, ad_out}, {8'd0, wd});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "ale", {15'd0, ale}, 16'd0);
        chk("R1", "rd_n", {15'd0, rd_n}, 16'd1);
        chk("R1", "wr_n", {15'd0, wr_n}, 16'd1);
        chk("R1", "ad_oe", {15'd0, ad_oe}, 16'd0);
        chk("R1", "io_m", {15'd0, io_m}, 16'd0);
        chk("R1", "status", {14'd0, s1, s0}, 16'd0);
        chk("R1", "done", {15'd0, done}, 16'd0);
        chk("R1", "req_ready", {15'd0, req_ready}, 16'd1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int kind = 0; kind < 4; kind++)
            for (int lng = 0; lng < 2; lng++)
                for (int w = 0; w < 4; w++) begin
                    logic [15:0] a;
                    logic [7:0] rv;
                    a  = 16'h1234 + 16'(kind * 16'h2111) + 16'(w * 16'h0457) + 16'(lng * 16'h8000);
                    rv = 8'h3C ^ 8'(kind * 37 + w * 11 + lng * 5);
                    run_cycle(kind, lng[0], a, ~a, ~rv, w, rv, (w == 1));
                end
        // R8: fetch takes pc even when req_addr matches nothing related
        run_cycle(0, 1'b1, 16'hA5A5, 16'h0F0F, 8'h00, 2, 8'h81, 1'b0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule